// File: doc/BRIEF.md
# Multi-Channel PWM Interval Timer

This block holds a small set of independent counter channels. Each one can be switched into a pulse-width mode, where it drives a square wave with a programmable high phase and a programmable low phase. Software writes and reads a compact 32-bit register space: one shared word of per-channel enable bits, plus a control word and a reload word for each channel. The reload word holds two 16-bit phase lengths. Its upper half sets the high phase and its lower half sets the low phase. Each phase runs for its field value plus one count tick.

Each channel picks its own count tick. It can count on every cycle of the bus clock, or on every rising edge of a slow external tick input. The external tick is brought into the bus clock domain through a synchroniser and an edge detector. A new reload value written while a channel runs takes effect only when the current period ends. Clearing the enable bit silences the output straight away.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset every output is 0, and every register (enable word at 0x1C, control words at 0x20 + 0x10·n, reload words at 0x24 + 0x10·n) reads as 0.
- R2: The enable bit of channel n sits at bit 3 + 4n of word 0x1C. Control words keep only their low 5 bits. Reload words keep all 32 bits. All other enable-word bits, unmapped addresses and addresses of channels beyond the channel count read as 0.
- R3: A channel drives its output only when its enable bit is 1 and control bits 2:0 equal 4. Any other mode value holds the output at 0.
- R4: On enable, the output is 0 in the first cycle after the enabling write. A period then begins in the high phase. The high phase lasts (reload bits 31:16) + 1 ticks and the low phase (reload bits 15:0) + 1 ticks, and the period repeats.
- R5: With control bit 3 = 1, the channel advances one tick on every bus clock cycle.
- R6: With control bit 3 = 0, the channel advances once per rising edge of the external tick, after a two-flop synchroniser. With no edges the output holds its level.
- R7: Writing 0 to a channel's enable bit drives its output to 0 from the cycle right after that write, even in the middle of a phase.
- R8: A reload value written while a channel runs is first used at the next period boundary. The period in progress completes with the old lengths.
- R9: With both phase fields at 0, the output alternates every tick, so neither 0% nor 100% duty is reachable.
- R10: Re-enabling a channel after a disable restarts a full high phase from the current reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick_i | input | 1 | Slow external count tick, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| pwm_o | output | NUM_CH | One waveform output per channel |

## Verification
The bench uses the default build: four channels, an 8-bit address and a two-stage synchroniser. With four channels, the enable bit of the last channel (bit 15) and the control word of channel 3 both lie inside the map. The channel-4 address 0x64 lies just past the end, so the bench can show that an out-of-range channel reads as zero. The 16-bit phase fields are driven only with small values, so whole periods, a mid-period reload, a mid-phase disable and the one-tick toggling case all fit in a few dozen cycles.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int DATA_W      = 32;
    localparam int PHASE_W     = 16;
    localparam int CTRL_W      = 5;
    localparam int MODE_W      = 3;
    localparam int CLK_SEL_BIT = 3;

    localparam logic [MODE_W-1:0] MODE_PWM = 3'd4;

    // register map
    localparam int ENA_OFS    = 'h1C;
    localparam int ENA_BIT0   = 3;
    localparam int ENA_STRIDE = 4;
    localparam int CH_BASE    = 'h20;
    localparam int CH_STRIDE  = 'h10;
    localparam int RELOAD_OFS = 4;

    typedef struct packed {
        logic               run;
        logic               hi_ph;
        logic [PHASE_W-1:0] cnt;
        logic [PHASE_W-1:0] lo_len;
    } chan_state_t;

endpackage

// File: rtl/pwm_tick_sync.sv
module pwm_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async_i,
    output logic tick_pulse_o
);

    // STAGES synchroniser flops plus one flop for edge detection
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], tick_async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign tick_pulse_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              bus_clk_sel_i,
    input  logic              ext_pulse_i,
    input  logic [DATA_W-1:0] reload_i,
    output logic              pwm_o
);

    localparam int HI_LSB = PHASE_W;
    localparam int HI_MSB = 2 * PHASE_W - 1;

    chan_state_t st_d, st_q;
    logic        tick;

    always_comb begin
        tick = bus_clk_sel_i | ext_pulse_i;
        st_d = st_q;
        if (!active_i) begin
            st_d.run   = 1'b0;
            st_d.hi_ph = 1'b0;
            st_d.cnt   = '0;
        end else if (!st_q.run) begin
            st_d.run    = 1'b1;
            st_d.hi_ph  = 1'b1;
            st_d.cnt    = reload_i[HI_MSB:HI_LSB];
            st_d.lo_len = reload_i[PHASE_W-1:0];
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                if (st_q.hi_ph) begin
                    st_d.hi_ph = 1'b0;
                    st_d.cnt   = st_q.lo_len;
                end else begin
                    // period boundary: pick up the latest reload word
                    st_d.hi_ph  = 1'b1;
                    st_d.cnt    = reload_i[HI_MSB:HI_LSB];
                    st_d.lo_len = reload_i[PHASE_W-1:0];
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.run & st_q.hi_ph & active_i;

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [DATA_W-1:0]              rdata_o,
    output logic [NUM_CH-1:0]              en_o,
    output logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]  reload_o
);

    typedef struct packed {
        logic [NUM_CH-1:0]             en;
        logic [NUM_CH-1:0][CTRL_W-1:0] ctrl;
        logic [NUM_CH-1:0][DATA_W-1:0] reload;
    } regs_t;

    localparam logic [ADDR_W-1:0] ENA_ADDR = ADDR_W'(ENA_OFS);

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int ch);
        return ADDR_W'(CH_BASE + CH_STRIDE * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] reload_addr(input int ch);
        return ADDR_W'(CH_BASE + CH_STRIDE * ch + RELOAD_OFS);
    endfunction

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (addr_i == ENA_ADDR) begin
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    r_d.en[ch] = wdata_i[ENA_BIT0 + ENA_STRIDE * ch];
                end
            end
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (addr_i == ctrl_addr(ch))   r_d.ctrl[ch]   = wdata_i[CTRL_W-1:0];
                if (addr_i == reload_addr(ch)) r_d.reload[ch] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ENA_ADDR) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                rdata_o[ENA_BIT0 + ENA_STRIDE * ch] = r_q.en[ch];
            end
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr_i == ctrl_addr(ch))   rdata_o = DATA_W'(r_q.ctrl[ch]);
            if (addr_i == reload_addr(ch)) rdata_o = r_q.reload[ch];
        end
    end

    assign en_o     = r_q.en;
    assign ctrl_o   = r_q.ctrl;
    assign reload_o = r_q.reload;

endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_tick_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [NUM_CH-1:0] pwm_o
);

    logic [NUM_CH-1:0]             chan_en;
    logic [NUM_CH-1:0][CTRL_W-1:0] chan_ctrl;
    logic [NUM_CH-1:0][DATA_W-1:0] chan_reload;
    logic [NUM_CH-1:0]             chan_active;
    logic                          ext_pulse;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (reg_rdata_o),
        .en_o     (chan_en),
        .ctrl_o   (chan_ctrl),
        .reload_o (chan_reload)
    );

    pwm_tick_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_async_i (ext_tick_i),
        .tick_pulse_o (ext_pulse)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign chan_active[ch] = chan_en[ch] &&
                                 (chan_ctrl[ch][MODE_W-1:0] == MODE_PWM);

        pwm_channel u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .active_i      (chan_active[ch]),
            .bus_clk_sel_i (chan_ctrl[ch][CLK_SEL_BIT]),
            .ext_pulse_i   (ext_pulse),
            .reload_i      (chan_reload[ch]),
            .pwm_o         (pwm_o[ch])
        );
    end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           reg_wr_i,
    input logic [ADDR_W-1:0]              reg_addr_i,
    input logic [31:0]                    reg_wdata_i,
    input logic [31:0]                    reg_rdata_o,
    input logic [NUM_CH-1:0]              pwm_o,
    input logic [NUM_CH-1:0]              chan_en,
    input logic [NUM_CH-1:0][CTRL_W-1:0]  chan_ctrl,
    input logic                           ext_pulse
);

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i < ADDR_W'(ENA_OFS)) |-> (reg_rdata_o == '0))
        else $error("unmapped address returned nonzero data");

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        logic act;
        assign act = chan_en[ch] && (chan_ctrl[ch][MODE_W-1:0] == MODE_PWM);

        // R3
        mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_ctrl[ch][MODE_W-1:0] != MODE_PWM) |-> !pwm_o[ch])
            else $error("output active outside waveform mode");

        // R7
        disable_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_i && reg_addr_i == ADDR_W'(ENA_OFS) &&
             !reg_wdata_i[ENA_BIT0 + ENA_STRIDE * ch]) |=> !pwm_o[ch])
            else $error("output still high after disable write");

        // R6
        ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act && $past(act) && $past(act, 2) &&
             !$past(chan_ctrl[ch][CLK_SEL_BIT]) && !$past(ext_pulse))
            |-> $stable(pwm_o[ch]))
            else $error("output moved without an external tick");
    end

endmodule

bind pwm_timer_top pwm_timer_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .pwm_o       (pwm_o),
    .chan_en     (chan_en),
    .chan_ctrl   (chan_ctrl),
    .ext_pulse   (ext_pulse)
);

// File: tb/pwm_timer_top_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_top_tb_top;

    localparam int NCH = 4;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ext_tick_i = 1'b0;
    logic           reg_wr_i = 1'b0;
    logic [AW-1:0]  reg_addr_i = '0;
    logic [31:0]    reg_wdata_i = '0;
    logic [31:0]    reg_rdata_o;
    logic [NCH-1:0] pwm_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  tick_run = 1'b0;
    bit  done = 1'b0;

    logic [NCH-1:0] exp_q[$];
    string          req_q[$];

    always #4 clk = ~clk;

    pwm_timer_top #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_tick_i  (ext_tick_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .pwm_o       (pwm_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [NCH-1:0] v, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            req_q.push_back(req);
        end
    endtask

    // drive at posedge+1, returns at posedge+1 after the write edge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_wr_i    = 1'b1;
        reg_addr_i  = a;
        reg_wdata_i = d;
        @(posedge clk);
        #1;
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        reg_addr_i = a;
        #1;
        chk(reg_rdata_o == exp, req, reg_rdata_o, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin : mon
        logic [NCH-1:0] e;
        string          r;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(pwm_o == e, r, 32'(pwm_o), 32'(e));
        end
    end

    // external tick generator: rising edge every 6 cycles
    initial begin
        forever begin
            @(posedge clk);
            if (tick_run) begin
                for (int i = 0; i < 2; i++) @(posedge clk);
                #1 ext_tick_i = ~ext_tick_i;
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int lo1, hi1, lo2, guard;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(pwm_o == '0, "R1", 32'(pwm_o), 0);
        rd(8'h1C, 0, "R1");
        rd(8'h20, 0, "R1");
        rd(8'h24, 0, "R1");
        rd(8'h54, 0, "R1");

        // R2 register map
        wr(8'h24, 32'h0002_0003);
        wr(8'h20, 32'h0000_000C);
        wr(8'h50, 32'h0000_00FF);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h64, 32'hFFFF_FFFF);
        rd(8'h24, 32'h0002_0003, "R2");
        rd(8'h20, 32'h0000_000C, "R2");
        rd(8'h50, 32'h0000_001F, "R2");
        rd(8'h28, 0, "R2");
        rd(8'h64, 0, "R2");
        rd(8'h1C, 0, "R2");
        idle(1);

        // R4/R5: enable all, only ch0 is in waveform mode (R3 for ch1..3)
        wr(8'h1C, 32'hFFFF_FFFF);                   // edge E0
        push(4'b0000, 1, "R4");
        push(4'b0001, 3, "R4 R5");
        push(4'b0000, 4, "R4 R3");
        rd(8'h1C, 32'h0000_8888, "R2");
        idle(2);
        // R8 reload mid-period: old period ends at E7
        wr(8'h24, 32'h0000_0000);                   // edge E3
        for (int i = 0; i < 4; i++) begin
            push(4'b0001, 1, "R8 R9");
            push(4'b0000, 1, "R8 R9");
        end
        idle(12);
        // R7 disable
        wr(8'h1C, 32'h0000_0000);                   // edge E16
        push(4'b0000, 2, "R7");
        wr(8'h24, 32'h0004_0001);                   // edge E17
        wr(8'h1C, 32'h0000_0008);                   // edge F0
        push(4'b0000, 1, "R4");
        push(4'b0001, 2, "R4");
        idle(2);
        wr(8'h1C, 32'h0000_0000);                   // edge F3, mid high phase
        push(4'b0000, 5, "R7");
        idle(4);
        // R10 re-enable
        wr(8'h1C, 32'h0000_0008);                   // edge G0
        push(4'b0000, 1, "R10");
        push(4'b0001, 5, "R10");
        push(4'b0000, 2, "R10");
        push(4'b0001, 5, "R10");
        idle(16);
        chk(exp_q.size() == 0, "R10", 32'(exp_q.size()), 0);

        // R6 external tick on ch1: high 2 ticks, low 1 tick
        wr(8'h34, 32'h0001_0000);
        wr(8'h30, 32'h0000_0004);
        wr(8'h1C, 32'h0000_0080);
        idle(3);
        chk(pwm_o[1] == 1'b1, "R6", 32'(pwm_o), 32'h2);
        idle(20);
        chk(pwm_o == 4'b0010, "R6", 32'(pwm_o), 32'h2);
        tick_run = 1'b1;
        guard = 0;
        @(negedge clk);
        while (pwm_o[1] == 1'b1 && guard < 200) begin guard++; @(negedge clk); end
        lo1 = 0;
        while (pwm_o[1] == 1'b0 && lo1 < 200) begin lo1++; @(negedge clk); end
        hi1 = 0;
        while (pwm_o[1] == 1'b1 && hi1 < 200) begin hi1++; @(negedge clk); end
        lo2 = 0;
        while (pwm_o[1] == 1'b0 && lo2 < 200) begin lo2++; @(negedge clk); end
        chk(lo1 == 6, "R6", 32'(lo1), 6);
        chk(hi1 == 12, "R6", 32'(hi1), 12);
        chk(lo2 == 6, "R6", 32'(lo2), 6);
        tick_run = 1'b0;
        idle(2);
        finish_up();
    end

endmodule